// File: doc/BRIEF.md
# SDRAM Command-Sequencing Controller

This block connects a simple word-wide host request port to a 32-bit, four-bank synchronous DRAM. After reset it waits for the memory's clock to settle. It then runs the start-up sequence: close every bank, issue two refreshes and program the mode register. Only after that does it accept host traffic.

Each accepted request is a complete transaction. The controller opens the addressed row and issues one READ or WRITE with auto-precharge. It then waits until that bank has closed again. A refresh timer raises a request at a fixed interval, and that request is served ahead of new host work whenever no row is open.

Requests flow in on a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the host must hold `req_valid` and the request fields steady. Read results leave on `rsp_valid`/`rsp_data` with no back-pressure, one beat per read, in request order. The sink must take every beat.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset is released, all four command pins remain in the deselect state for INIT_WAIT clock cycles. `req_ready` stays low until the mode register has been loaded.
- R2: The start-up commands come in this order: PRECHARGE with address bit 10 high, AUTO REFRESH, AUTO REFRESH, LOAD MODE. Consecutive start-up commands are spaced by T_RP, T_RFC and T_RFC clocks.
- R3: The LOAD MODE command carries this word on the address pins: bits [2:0] = 000 (single-word burst), bit 3 = BURST_INTERLEAVE, bits [6:4] = CAS_LAT, and all other bits 0.
- R4: An accepted request puts ACTIVE on the pins in the next cycle. The bank field `req_addr[9:8]` goes on BA and the row field `req_addr[20:10]` goes on A. The column is `req_addr[7:0]`.
- R5: READ or WRITE to the same bank follows ACTIVE by exactly T_RCD clocks. It carries the column on A[7:0] and address bit 10 high, which requests auto-precharge.
- R6: During the WRITE cycle, DQ is driven with the write data and DQM equals the inverted byte enables. Bit i of the enables guards byte i, and masked bytes keep their old memory contents.
- R7: A READ drives DQM to 0000. DQ is sampled CAS_LAT clocks after the device sees the READ, and `rsp_valid` pulses high for one cycle with that word, in request order.
- R8: ACTIVE or AUTO REFRESH is issued no sooner than CAS_LAT+T_RP clocks after a READ, or T_WR+T_RP clocks after a WRITE.
- R9: AUTO REFRESH is issued every REF_INT clocks, give or take the length of one transaction. It is issued only when no row is open, and it takes priority over a waiting host request.
- R10: `req_ready` is low in the cycle after a request is accepted, and stays low until the transaction has finished.
- R11: Every command drives chip select low. In cycles with no command, all four command pins are high (deselect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the DRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | {row[10:0], bank[1:0], column[7:0]} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i guards byte i |
| rsp_valid | output | 1 | Read data beat valid |
| rsp_data | output | 32 | Read data |
| init_done | output | 1 | Start-up sequence complete |
| sd_cs_n | output | 1 | DRAM chip select, active low |
| sd_ras_n | output | 1 | DRAM row strobe |
| sd_cas_n | output | 1 | DRAM column strobe |
| sd_we_n | output | 1 | DRAM write enable |
| sd_ba | output | 2 | DRAM bank address |
| sd_addr | output | 11 | DRAM address pins |
| sd_dqm | output | 4 | DRAM byte masks |
| sd_dq_out | output | 32 | Data toward the DRAM |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 32 | Data from the DRAM |

## Verification
ACTIVE is visible one cycle after the handshake edge. The column command follows T_RCD cycles later. A read result is registered CAS_LAT+1 edges after the edge that drove READ. The bench reads every output at the falling edge, so the value it sees is the one registered at the preceding rising edge.

A cycle-counting memory model beside the controller checks the command spacing (R2, R5, R8, R9) against its own counter. It returns read data exactly CAS_LAT cycles after it samples READ. A scoreboard queue checks each read result in order against expectations built from earlier writes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // Command bits are {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_LMR   = 4'b0000
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IPRE, ST_IREF1, ST_IREF2, ST_ILMR, ST_IDLE, ST_COL
  } seq_st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_INT = 2230
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(REF_INT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (en) begin
      if (cnt == CW'(REF_INT - 1)) begin
        cnt <= '0;
        due <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (ack) due <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [CAS_LAT-1:0] sh;

  generate
    if (CAS_LAT > 1) begin : g_long
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[CAS_LAT-2:0], rd_fire};
      end
    end else begin : g_short
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= rd_fire;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sh[CAS_LAT-1];
      if (sh[CAS_LAT-1]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 11, parameter int COL_W = 8, parameter int BANK_W = 2,
  parameter int DATA_W = 32, parameter int CAS_LAT = 2, parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int INIT_WAIT = 14300, parameter int T_RCD = 3, parameter int T_RP = 3,
  parameter int T_RFC = 9, parameter int T_WR = 2, parameter int T_MRD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  input  logic                          ref_due,
  output logic                          ref_ack,
  output logic                          init_done,
  output sd_cmd_e                       cmd,
  output logic [BANK_W-1:0]             ba,
  output logic [ROW_W-1:0]              addr,
  output logic [DATA_W/8-1:0]           dqm,
  output logic [DATA_W-1:0]             dq_out,
  output logic                          dq_oe,
  output logic                          rd_fire
);
  localparam int HOLD_W = $clog2(INIT_WAIT + T_RFC + T_RP + T_WR + CAS_LAT + T_RCD + T_MRD + 2);
  localparam int AP_BIT = ROW_W - 1;
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({3'(CAS_LAT), BURST_INTERLEAVE, 3'b000});
  localparam logic [HOLD_W-1:0] RD_GAP = HOLD_W'(CAS_LAT + T_RP - 1);
  localparam logic [HOLD_W-1:0] WR_GAP = HOLD_W'(T_WR + T_RP - 1);

  seq_st_e                st;
  logic [HOLD_W-1:0]      hold;
  logic                   lat_we;
  logic [BANK_W-1:0]      lat_bank;
  logic [COL_W-1:0]       lat_col;
  logic [DATA_W-1:0]      lat_data;
  logic [DATA_W/8-1:0]    lat_be;

  wire idle_free = (st == ST_IDLE) && (hold == '0);
  assign req_ready = idle_free && !ref_due;
  assign ref_ack   = idle_free && ref_due;
  assign init_done = (st == ST_IDLE) || (st == ST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IPRE;
      hold <= HOLD_W'(INIT_WAIT - 1);
      cmd <= CMD_DESEL; ba <= '0; addr <= '0; dqm <= '0;
      dq_out <= '0; dq_oe <= 1'b0; rd_fire <= 1'b0;
      lat_we <= 1'b0; lat_bank <= '0; lat_col <= '0; lat_data <= '0; lat_be <= '0;
    end else begin
      cmd <= CMD_DESEL;
      dq_oe <= 1'b0;
      dqm <= '0;
      rd_fire <= 1'b0;
      if (hold != '0) begin
        hold <= hold - 1'b1;
      end else begin
        case (st)
          ST_IPRE: begin
            cmd <= CMD_PRE; addr <= AP_MASK;
            hold <= HOLD_W'(T_RP - 1); st <= ST_IREF1;
          end
          ST_IREF1: begin
            cmd <= CMD_REF; hold <= HOLD_W'(T_RFC - 1); st <= ST_IREF2;
          end
          ST_IREF2: begin
            cmd <= CMD_REF; hold <= HOLD_W'(T_RFC - 1); st <= ST_ILMR;
          end
          ST_ILMR: begin
            cmd <= CMD_LMR; addr <= MODE_WORD; ba <= '0;
            hold <= HOLD_W'(T_MRD - 1); st <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_due) begin
              cmd <= CMD_REF; hold <= HOLD_W'(T_RFC - 1);
            end else if (req_valid) begin
              cmd <= CMD_ACT;
              ba <= req_addr[COL_W +: BANK_W];
              addr <= req_addr[COL_W+BANK_W +: ROW_W];
              lat_we <= req_write;
              lat_bank <= req_addr[COL_W +: BANK_W];
              lat_col <= req_addr[COL_W-1:0];
              lat_data <= req_wdata;
              lat_be <= req_be;
              hold <= HOLD_W'(T_RCD - 1);
              st <= ST_COL;
            end
          end
          ST_COL: begin
            ba <= lat_bank;
            addr <= ROW_W'(lat_col) | AP_MASK;
            if (lat_we) begin
              cmd <= CMD_WR; dq_out <= lat_data; dq_oe <= 1'b1;
              dqm <= ~lat_be; hold <= WR_GAP;
            end else begin
              cmd <= CMD_RD; rd_fire <= 1'b1; hold <= RD_GAP;
            end
            st <= ST_IDLE;
          end
          default: st <= ST_IPRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 11, parameter int COL_W = 8, parameter int BANK_W = 2,
  parameter int DATA_W = 32, parameter int CAS_LAT = 2, parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int INIT_WAIT = 14300, parameter int REF_INT = 2230,
  parameter int T_RCD = 3, parameter int T_RP = 3, parameter int T_RFC = 9,
  parameter int T_WR = 2, parameter int T_MRD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          init_done,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  sd_cmd_e cmd;
  logic    ref_due, ref_ack, rd_fire;

  sdram_ref_timer #(.REF_INT(REF_INT)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .due(ref_due)
  );

  sdram_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .CAS_LAT(CAS_LAT), .BURST_INTERLEAVE(BURST_INTERLEAVE), .INIT_WAIT(INIT_WAIT),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ref_due(ref_due), .ref_ack(ref_ack), .init_done(init_done), .cmd(cmd),
    .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe),
    .rd_fire(rd_fire)
  );

  sdram_rd_pipe #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rdp (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int ROW_W = 11, parameter int CAS_LAT = 2, parameter int T_RCD = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic             rsp_valid,
  input logic             req_valid,
  input logic             req_ready
);
  wire [3:0] c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  wire is_act = (c == 4'b0011);
  wire is_rd  = (c == 4'b0101);
  wire is_wr  = (c == 4'b0100);
  wire is_ref = (c == 4'b0001);
  wire is_lmr = (c == 4'b0000);

  logic [7:0] since_act;
  logic       lmr_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      lmr_seen  <= 1'b0;
    end else begin
      if (is_act) since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
      if (is_lmr) lmr_seen <= 1'b1;
    end
  end

  assert_ready_after_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lmr_seen || is_lmr));
  assert_accept_opens_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_act);
  assert_col_autoprecharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> sd_addr[ROW_W-1]);
  assert_col_after_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> (since_act == 8'(T_RCD)));
  assert_drive_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> is_wr);
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(is_rd, CAS_LAT + 1));
  assert_refresh_not_mid_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (since_act > 8'(T_RCD)));
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(.ROW_W(ROW_W), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe), .rsp_valid(rsp_valid),
  .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/sim_sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_seq_ctrl;
  localparam int CL = 3, IW = 50, RI = 400, TRCD = 2, TRP = 2, TRFC = 5, TWR = 2, TMRD = 2;
  localparam bit BI = 1'b1;
  localparam int SLK = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rsp_valid, init_done;
  logic [31:0] rsp_data, sd_dq_out;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [10:0] sd_addr;
  logic [3:0] sd_dqm;
  logic [31:0] dl [0:3];
  wire  [31:0] sd_dq_in = dl[CL-1];

  always #2.5 clk = ~clk;

  sdram_seq_ctrl #(.CAS_LAT(CL), .BURST_INTERLEAVE(BI), .INIT_WAIT(IW), .REF_INT(RI),
    .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_WR(TWR), .T_MRD(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int cyc = 0, init_idx = 0, prev_init = 0, last_ref = 0, ref_cnt = 0;
  bit lmr_seen = 1'b0, r1_bad = 1'b0;
  bit bopen [4];
  int rdy_at [4];
  int act_at [4];
  logic [10:0] orow [4];
  logic [31:0] mem [int];

  function automatic logic [31:0] mem_rd(int k);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    int k;
    logic [31:0] w;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    dl[1] <= dl[0]; dl[2] <= dl[1]; dl[3] <= dl[2];
    dl[0] <= 32'h0;
    if (rst_n) begin
      cyc++;
      if (c != 4'b1111 && init_idx < 4) begin
        if (init_idx == 0) chk(cyc > IW, "R1 first command cycle", cyc, IW + 1);
        case (init_idx)
          0: chk(c == 4'b0010 && sd_addr[10], "R2 init step0 PRECHARGE all", {c, sd_addr}, {4'b0010, 11'h400});
          1: chk(c == 4'b0001 && cyc - prev_init == TRP, "R2 init step1 REFRESH", {c, 32'(cyc - prev_init)}, {4'b0001, 32'(TRP)});
          2: chk(c == 4'b0001 && cyc - prev_init == TRFC, "R2 init step2 REFRESH", {c, 32'(cyc - prev_init)}, {4'b0001, 32'(TRFC)});
          default: chk(c == 4'b0000 && cyc - prev_init == TRFC, "R2 init step3 LOAD MODE", {c, 32'(cyc - prev_init)}, {4'b0000, 32'(TRFC)});
        endcase
        prev_init = cyc;
        init_idx++;
      end
      case (c)
        4'b0011: begin
          chk(!bopen[sd_ba] && cyc >= rdy_at[sd_ba], "R8 ACTIVE too early", cyc, rdy_at[sd_ba]);
          bopen[sd_ba] = 1'b1; orow[sd_ba] = sd_addr; act_at[sd_ba] = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(bopen[sd_ba] && cyc - act_at[sd_ba] == TRCD, "R5 column spacing", cyc - act_at[sd_ba], TRCD);
          chk(sd_addr[10] == 1'b1, "R5 auto-precharge bit", sd_addr[10], 1);
          k = int'({sd_ba, orow[sd_ba], sd_addr[7:0]});
          if (c == 4'b0100) begin
            chk(sd_dq_oe, "R6 write drive enable", sd_dq_oe, 1);
            w = mem_rd(k);
            for (int i = 0; i < 4; i++) if (!sd_dqm[i]) w[8*i +: 8] = sd_dq_out[8*i +: 8];
            mem[k] = w;
            rdy_at[sd_ba] = cyc + TWR + TRP;
          end else begin
            chk(sd_dqm == 4'b0000, "R7 read mask", sd_dqm, 0);
            dl[0] <= mem_rd(k);
            rdy_at[sd_ba] = cyc + CL + TRP;
          end
          bopen[sd_ba] = 1'b0;
        end
        4'b0010: for (int b = 0; b < 4; b++) rdy_at[b] = cyc + TRP;
        4'b0001: begin
          for (int b = 0; b < 4; b++)
            chk(!bopen[b] && cyc >= rdy_at[b], "R9 refresh with bank busy", cyc, rdy_at[b]);
          for (int b = 0; b < 4; b++) rdy_at[b] = cyc + TRFC;
          if (lmr_seen) begin
            if (last_ref > 0)
              chk(cyc - last_ref >= RI - SLK && cyc - last_ref <= RI + SLK,
                  "R9 refresh interval", cyc - last_ref, RI);
            last_ref = cyc;
            ref_cnt++;
          end
        end
        4'b0000: begin
          chk(sd_addr == 11'({3'(CL), BI, 3'b000}) && sd_ba == 2'b00, "R3 mode word",
              sd_addr, 11'({3'(CL), BI, 3'b000}));
          lmr_seen = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && req_ready && !lmr_seen) r1_bad = 1'b1;

  // ---------------- scoreboard ----------------
  logic [31:0] ref_mem [int];
  logic [31:0] expq [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected read beat", rsp_data, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(rsp_data === e, "R7 read data", rsp_data, e);
      end
    end
  end

  task automatic do_req(input bit w, input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
    int k;
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011 && sd_ba == a[9:8] && sd_addr == a[20:10],
        "R4 ACTIVE after accept", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr},
        {4'b0011, a[9:8], a[20:10]});
    chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
    req_valid = 1'b0;
    k = int'({a[9:8], a[20:10], a[7:0]});
    v = ref_mem.exists(k) ? ref_mem[k] : 32'h0;
    if (w) begin
      for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
      ref_mem[k] = v;
    end else expq.push_back(v);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] x;
    int lowcs, rc0;
    x = 32'h1234_5678;
    for (int b = 0; b < 4; b++) begin bopen[b] = 1'b0; rdy_at[b] = 0; act_at[b] = 0; orow[b] = '0; end
    for (int i = 0; i < 4; i++) dl[i] = '0;
    repeat (4) @(negedge clk);
    chk(!req_ready && sd_cs_n && !rsp_valid, "R1 reset state", {req_ready, sd_cs_n, rsp_valid}, 3'b010);
    rst_n = 1'b1;
    // full write then read, same location
    do_req(1'b1, {11'h123, 2'd1, 8'h45}, 32'hDEAD_BEEF, 4'hF);
    do_req(1'b0, {11'h123, 2'd1, 8'h45}, 32'h0, 4'hF);
    // byte-masked merge (R6)
    do_req(1'b1, {11'h7FF, 2'd3, 8'hFF}, 32'h1111_1111, 4'hF);
    do_req(1'b1, {11'h7FF, 2'd3, 8'hFF}, 32'hAABB_CCDD, 4'b0101);
    do_req(1'b0, {11'h7FF, 2'd3, 8'hFF}, 32'h0, 4'hF);
    // never written location reads zero
    do_req(1'b0, {11'h000, 2'd0, 8'h00}, 32'h0, 4'hF);
    // same row different banks, back-to-back reads
    for (int b = 0; b < 4; b++) do_req(1'b1, {11'h055, 2'(b), 8'h10}, 32'hC0DE_0000 + b, 4'hF);
    for (int b = 0; b < 4; b++) do_req(1'b0, {11'h055, 2'(b), 8'h10}, 32'h0, 4'hF);
    // pseudo-random mix on a small address set
    for (int n = 0; n < 60; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      do_req(x[0], {9'h0, x[5:4], 2'(x[7:6]), 6'h0, x[9:8]}, x, x[13:10]);
    end
    // idle window: only refreshes may appear (R9, R11)
    repeat (20) @(negedge clk);
    lowcs = 0; rc0 = ref_cnt;
    for (int n = 0; n < 3 * RI; n++) begin
      @(negedge clk);
      if (!sd_cs_n) lowcs++;
    end
    chk(lowcs == ref_cnt - rc0 && lowcs >= 2, "R11 idle deselect", lowcs, ref_cnt - rc0);
    // traffic again after refreshes
    do_req(1'b0, {11'h123, 2'd1, 8'h45}, 32'h0, 4'hF);
    do_req(1'b1, {11'h001, 2'd2, 8'h02}, 32'h0BAD_F00D, 4'b1000);
    do_req(1'b0, {11'h001, 2'd2, 8'h02}, 32'h0, 4'hF);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R7 all reads answered", expq.size(), 0);
    chk(!r1_bad && lmr_seen && init_done, "R1 ready only after mode load", {r1_bad, lmr_seen, init_done}, 3'b011);
    chk(ref_cnt >= (cyc - IW) / RI - 2, "R9 refresh count", ref_cnt, (cyc - IW) / RI - 2);
    finish_run();
  end
endmodule